// File: doc/BRIEF.md
# Cascaded Audio Clock Divider

This block produces the two clocks an audio serial port needs: a high-rate master clock (HCK) and a serial bit clock (SCK). Both come from one source clock through a chain of counters: a prescaler that divides by 1 or by 8, a main counter that divides by any integer from 1 to 256, and a fine counter that divides by any integer from 1 to 16. The fine counter acts only on the bit-clock path. Each output is a toggle flip-flop, so both clocks keep a 50% duty cycle whatever the stage values are.

There are two identical channels: channel 0 serves transmit and channel 1 serves receive. Each channel has its own divider values, its own full-bypass control and its own HCK direction bit. In bypass the source clock drives HCK directly, and SCK is cut from the source by the fine stage alone. When the direction bit selects input, the HCK pin is driven from outside. The block then samples that pin, and each of its edges clocks the fine stage.

Divider values are taken from the input ports into active registers only when SCK toggles. A value written in the middle of a period therefore takes effect at a clean edge.

Top module: `acd_clkgen`

## Requirements
- R1: While `rst` is high, `hck_o` and `sck_o` are low on every channel, bypass included. After the first clock edge with `rst` low, the first HCK rising edge comes P*M source cycles later.
- R2: In divided mode (`byp_i`=0, `hck_dir_i`=1), each HCK high phase and each low phase lasts P*M source cycles. Here P is 8 when `pre8_i`=1 and 1 when `pre8_i`=0, and M is the `main_i` field plus 1 (field 0..255).
- R3: In divided mode, each SCK high phase and each low phase lasts P*M*F source cycles, where F is the `fine_i` field plus 1 (field 0..15).
- R4: When P*M or P*M*F is odd, the high and low phases are still equal.
- R5: With `byp_i`=1 and `hck_dir_i`=1, `hck_o` equals the source clock, and each SCK phase lasts F source cycles.
- R6: `hck_oe_o` equals `hck_dir_i`. With `hck_dir_i`=0, `hck_o` is held low and each SCK phase lasts F edges of `hck_pin_i`, counting both edges.
- R7: New `pre8_i`/`main_i`/`fine_i` values take effect only at an SCK toggle. Every HCK and SCK phase measured across a change lasts either the old length or the new one.
- R8: The transmit and receive channels run independently. A setting on one channel does not change the phase lengths of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst | input | 1 | Synchronous reset, active high |
| pre8_i | input | NCH | Prescaler select per channel: 1 = divide by 8, 0 = divide by 1 |
| main_i | input | NCH*MAIN_W | Main divider field per channel (ratio = field + 1) |
| fine_i | input | NCH*FINE_W | Fine divider field per channel (ratio = field + 1) |
| byp_i | input | NCH | Full bypass per channel |
| hck_dir_i | input | NCH | HCK direction: 1 = driven out, 0 = taken from pin |
| hck_pin_i | input | NCH | External HCK, used when the direction bit is 0 |
| hck_o | output | NCH | HCK output |
| hck_oe_o | output | NCH | HCK pin output enable |
| sck_o | output | NCH | Serial bit clock |

## Verification
The reload of the active divider values and the terminal count of the divider chain fall in the same cycle by design. A new value that arrives in the cycle of that terminal count must be either taken cleanly or left for the next period, and must never cut a phase short. The bench provokes this by switching one channel between two settings at a sweep of offsets from an SCK rising edge, so that the switch lands before the toggle, on it and after it. It judges the result by requiring every SCK phase to equal the old or the new length. A monitor process runs at the same time and requires every HCK phase to have one of the two lengths as well.

// File: rtl/acd_pkg.sv
package acd_pkg;

  localparam int PRE_W = 3;

  // prescaler terminal value: ratio 8 or ratio 1
  function automatic logic [PRE_W-1:0] pre_limit(input logic div8);
    return div8 ? PRE_W'(7) : PRE_W'(0);
  endfunction

  // cycles per HCK phase for active terminal values of the two upper stages
  function automatic int unsigned stage_product(input int unsigned pre_lim,
                                                input int unsigned main_lim);
    return (pre_lim + 1) * (main_lim + 1);
  endfunction

endpackage

// File: rtl/acd_stage.sv
module acd_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en_i,
  input  logic         clr_i,
  input  logic         load_i,
  input  logic [W-1:0] lim_i,
  output logic [W-1:0] lim_o,
  output logic         tick_o
);
  logic [W-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == lim_o);

  always_ff @(posedge clk) begin
    if (rst || clr_i || tick_o) cnt_q <= '0;
    else if (en_i)              cnt_q <= cnt_q + 1'b1;
  end

  // active terminal value, refreshed from the shadow input only on request
  always_ff @(posedge clk) begin
    if (rst || load_i) lim_o <= lim_i;
  end
endmodule

// File: rtl/acd_pin_sync.sv
module acd_pin_sync (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic edge_o
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= pin_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign edge_o = s2_q ^ s3_q;
endmodule

// File: rtl/acd_channel.sv
module acd_channel
  import acd_pkg::*;
#(
  parameter int MAIN_W = 8,
  parameter int FINE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pre8_i,
  input  logic [MAIN_W-1:0] main_i,
  input  logic [FINE_W-1:0] fine_i,
  input  logic              byp_i,
  input  logic              dir_i,
  input  logic              pin_i,
  output logic              hck_o,
  output logic              hck_oe_o,
  output logic              sck_o,
  output logic              pre_tick_o,
  output logic              main_tick_o,
  output logic              fine_tick_o,
  output logic              hck_q_o,
  output logic [PRE_W-1:0]  pre_act_o,
  output logic [MAIN_W-1:0] main_act_o,
  output logic [FINE_W-1:0] fine_act_o
);
  logic pin_edge;
  logic fine_en;
  logic hck_q, sck_q;

  acd_pin_sync u_sync (
    .clk   (clk),
    .rst   (rst),
    .pin_i (pin_i),
    .edge_o(pin_edge)
  );

  // prescaler: restarts and reloads at every SCK toggle
  acd_stage #(.W(PRE_W)) u_pre (
    .clk   (clk),
    .rst   (rst),
    .en_i  (1'b1),
    .clr_i (fine_tick_o),
    .load_i(fine_tick_o),
    .lim_i (pre_limit(pre8_i)),
    .lim_o (pre_act_o),
    .tick_o(pre_tick_o)
  );

  acd_stage #(.W(MAIN_W)) u_main (
    .clk   (clk),
    .rst   (rst),
    .en_i  (pre_tick_o),
    .clr_i (fine_tick_o),
    .load_i(fine_tick_o),
    .lim_i (main_i),
    .lim_o (main_act_o),
    .tick_o(main_tick_o)
  );

  // fine stage input: pin edges, every source cycle, or the HCK-rate tick
  always_comb begin
    if (!dir_i)     fine_en = pin_edge;
    else if (byp_i) fine_en = 1'b1;
    else            fine_en = main_tick_o;
  end

  acd_stage #(.W(FINE_W)) u_fine (
    .clk   (clk),
    .rst   (rst),
    .en_i  (fine_en),
    .clr_i (1'b0),
    .load_i(fine_tick_o),
    .lim_i (fine_i),
    .lim_o (fine_act_o),
    .tick_o(fine_tick_o)
  );

  // the fixed divide-by-two: one toggle flip-flop per output
  always_ff @(posedge clk) begin
    if (rst) begin
      hck_q <= 1'b0;
      sck_q <= 1'b0;
    end else begin
      if (main_tick_o) hck_q <= ~hck_q;
      if (fine_tick_o) sck_q <= ~sck_q;
    end
  end

  always_comb begin
    if (!dir_i)     hck_o = 1'b0;
    else if (byp_i) hck_o = clk & ~rst;
    else            hck_o = hck_q;
  end

  assign hck_oe_o = dir_i;
  assign sck_o    = sck_q;
  assign hck_q_o  = hck_q;
endmodule

// File: rtl/acd_clkgen.sv
module acd_clkgen
  import acd_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int MAIN_W = 8,
  parameter int FINE_W = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NCH-1:0]               pre8_i,
  input  logic [NCH-1:0][MAIN_W-1:0]   main_i,
  input  logic [NCH-1:0][FINE_W-1:0]   fine_i,
  input  logic [NCH-1:0]               byp_i,
  input  logic [NCH-1:0]               hck_dir_i,
  input  logic [NCH-1:0]               hck_pin_i,
  output logic [NCH-1:0]               hck_o,
  output logic [NCH-1:0]               hck_oe_o,
  output logic [NCH-1:0]               sck_o
);
  // internal events brought out per channel for the checker
  logic [NCH-1:0]             pre_tick_w;
  logic [NCH-1:0]             main_tick_w;
  logic [NCH-1:0]             fine_tick_w;
  logic [NCH-1:0]             hck_q_w;
  logic [NCH-1:0][PRE_W-1:0]  pre_act_w;
  logic [NCH-1:0][MAIN_W-1:0] main_act_w;
  logic [NCH-1:0][FINE_W-1:0] fine_act_w;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    acd_channel #(.MAIN_W(MAIN_W), .FINE_W(FINE_W)) u_chan (
      .clk        (clk),
      .rst        (rst),
      .pre8_i     (pre8_i[ch]),
      .main_i     (main_i[ch]),
      .fine_i     (fine_i[ch]),
      .byp_i      (byp_i[ch]),
      .dir_i      (hck_dir_i[ch]),
      .pin_i      (hck_pin_i[ch]),
      .hck_o      (hck_o[ch]),
      .hck_oe_o   (hck_oe_o[ch]),
      .sck_o      (sck_o[ch]),
      .pre_tick_o (pre_tick_w[ch]),
      .main_tick_o(main_tick_w[ch]),
      .fine_tick_o(fine_tick_w[ch]),
      .hck_q_o    (hck_q_w[ch]),
      .pre_act_o  (pre_act_w[ch]),
      .main_act_o (main_act_w[ch]),
      .fine_act_o (fine_act_w[ch])
    );
  end
endmodule

// File: rtl/acd_clkgen_chk.sv
module acd_clkgen_chk
  import acd_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int MAIN_W = 8,
  parameter int FINE_W = 4
) (
  input logic                       clk,
  input logic                       rst,
  input logic [NCH-1:0]             byp_i,
  input logic [NCH-1:0]             dir_i,
  input logic [NCH-1:0]             pre_tick,
  input logic [NCH-1:0]             main_tick,
  input logic [NCH-1:0]             fine_tick,
  input logic [NCH-1:0]             hck_q,
  input logic [NCH-1:0]             sck_q,
  input logic [NCH-1:0][PRE_W-1:0]  pre_act,
  input logic [NCH-1:0][MAIN_W-1:0] main_act,
  input logic [NCH-1:0][FINE_W-1:0] fine_act
);
  localparam int RUN_W = PRE_W + MAIN_W + 1;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chk
    logic [RUN_W-1:0] run_q;
    logic             clean_q;

    // cycles since the last HCK-rate tick, valid only while divided mode held
    always_ff @(posedge clk) begin
      if (rst || main_tick[ch]) run_q <= '0;
      else                      run_q <= run_q + 1'b1;
    end

    always_ff @(posedge clk) begin
      if (rst)                          clean_q <= 1'b1;
      else if (byp_i[ch] || !dir_i[ch]) clean_q <= 1'b0;
      else if (main_tick[ch])           clean_q <= 1'b1;
    end

    AST_RESET_LOW: assert property (@(posedge clk)
      rst |=> (!hck_q[ch] && !sck_q[ch])); // R1

    AST_HCK_HALF: assert property (@(posedge clk) disable iff (rst)
      (clean_q && main_tick[ch] && !byp_i[ch] && dir_i[ch]) |->
        (int'(run_q) + 1 == int'(stage_product(pre_act[ch], main_act[ch])))); // R2

    AST_MAIN_NEEDS_PRE: assert property (@(posedge clk) disable iff (rst)
      main_tick[ch] |-> pre_tick[ch]); // R2

    AST_SCK_NESTED: assert property (@(posedge clk) disable iff (rst)
      (fine_tick[ch] && !byp_i[ch] && dir_i[ch]) |-> main_tick[ch]); // R3

    AST_SCK_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (rst)
      !fine_tick[ch] |=> $stable(sck_q[ch])); // R3

    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (rst)
      !fine_tick[ch] |=> ($stable(pre_act[ch]) && $stable(main_act[ch]) &&
                          $stable(fine_act[ch]))); // R7
  end
endmodule

bind acd_clkgen acd_clkgen_chk #(
  .NCH(NCH), .MAIN_W(MAIN_W), .FINE_W(FINE_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .byp_i    (byp_i),
  .dir_i    (hck_dir_i),
  .pre_tick (pre_tick_w),
  .main_tick(main_tick_w),
  .fine_tick(fine_tick_w),
  .hck_q    (hck_q_w),
  .sck_q    (sck_o),
  .pre_act  (pre_act_w),
  .main_act (main_act_w),
  .fine_act (fine_act_w)
);

// File: tb/tb_acd_clkgen.sv
module tb_acd_clkgen;
  localparam int CLK_PERIOD = 10;
  localparam int NCH        = 2;
  localparam int MAIN_W     = 8;
  localparam int FINE_W     = 4;
  localparam int EXT_HALF   = 5;
  localparam int LIMIT      = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NCH-1:0]             pre8_i    = '0;
  logic [NCH-1:0][MAIN_W-1:0] main_i    = '0;
  logic [NCH-1:0][FINE_W-1:0] fine_i    = '0;
  logic [NCH-1:0]             byp_i     = '0;
  logic [NCH-1:0]             hck_dir_i = '1;
  logic [NCH-1:0]             hck_pin_i = '0;
  logic [NCH-1:0]             hck_o, hck_oe_o, sck_o;

  int checks = 0;
  int errors = 0;
  bit ext_en [NCH];
  bit mon_en = 1'b0;
  int mon_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acd_clkgen #(.NCH(NCH), .MAIN_W(MAIN_W), .FINE_W(FINE_W)) dut (
    .clk(clk), .rst(rst), .pre8_i(pre8_i), .main_i(main_i), .fine_i(fine_i),
    .byp_i(byp_i), .hck_dir_i(hck_dir_i), .hck_pin_i(hck_pin_i),
    .hck_o(hck_o), .hck_oe_o(hck_oe_o), .sck_o(sck_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic bit smp(input int ch, input bit is_sck);
    return is_sck ? sck_o[ch] : hck_o[ch];
  endfunction

  // length of one high and the following low phase, sampled at falling edges
  task automatic measure(input int ch, input bit is_sck, output int hi, output int lo);
    bit prev;
    int n;
    hi = -1; lo = -1;
    prev = smp(ch, is_sck);
    n = 0;
    forever begin
      @(negedge clk);
      n++;
      if (!prev && smp(ch, is_sck)) break;
      prev = smp(ch, is_sck);
      if (n > LIMIT) return;
    end
    hi = 1;
    forever begin
      @(negedge clk);
      if (!smp(ch, is_sck)) break;
      hi++;
      if (hi > LIMIT) return;
    end
    lo = 1;
    forever begin
      @(negedge clk);
      if (smp(ch, is_sck)) break;
      lo++;
      if (lo > LIMIT) return;
    end
  endtask

  task automatic settle(input int ch);
    int h, l;
    measure(ch, 1'b1, h, l);
    measure(ch, 1'b1, h, l);
  endtask

  task automatic set_cfg(input int ch, input bit p8, input int m, input int f,
                         input bit byp, input bit dir);
    pre8_i[ch]    = p8;
    main_i[ch]    = MAIN_W'(m);
    fine_i[ch]    = FINE_W'(f);
    byp_i[ch]     = byp;
    hck_dir_i[ch] = dir;
    ext_en[ch]    = !dir;
  endtask

  // external HCK source for pin mode
  initial begin
    int ecnt [NCH];
    for (int c = 0; c < NCH; c++) ecnt[c] = 0;
    forever begin
      @(negedge clk);
      for (int c = 0; c < NCH; c++) begin
        if (ext_en[c]) begin
          ecnt[c]++;
          if (ecnt[c] == EXT_HALF) begin
            hck_pin_i[c] = ~hck_pin_i[c];
            ecnt[c] = 0;
          end
        end
      end
    end
  end

  // HCK phase monitor on channel 0 during reprogramming
  initial begin
    bit first, prev;
    int run;
    first = 1'b1; prev = 1'b0; run = 0;
    forever begin
      @(negedge clk);
      if (!mon_en) begin
        first = 1'b1; run = 0; prev = hck_o[0];
      end else if (hck_o[0] == prev) begin
        run++;
      end else begin
        if (!first && run != 3 && run != 5) mon_bad++;
        first = 1'b0; run = 1; prev = hck_o[0];
      end
    end
  end

  task automatic t_reset();
    int bad, n;
    set_cfg(0, 1'b0, 3, 1, 1'b0, 1'b1);
    set_cfg(1, 1'b0, 0, 0, 1'b1, 1'b1);
    bad = 0;
    repeat (6) begin
      @(posedge clk); #1;
      if (hck_o != '0 || sck_o != '0) bad++;
      @(negedge clk); #1;
      if (hck_o != '0 || sck_o != '0) bad++;
    end
    check(bad == 0, "R1 outputs low in reset", bad, 0);
    @(negedge clk);
    rst = 1'b0;
    n = 0;
    while (!hck_o[0] && n < 100) begin
      @(negedge clk);
      n++;
    end
    check(n == 4, "R1 first HCK rise after reset", n, 4);
  endtask

  task automatic t_divided(input int ch, input bit p8, input int m, input int f,
                           input string tag);
    int h, l, ph, ps;
    set_cfg(ch, p8, m, f, 1'b0, 1'b1);
    settle(ch);
    ph = (p8 ? 8 : 1) * (m + 1);
    ps = ph * (f + 1);
    measure(ch, 1'b0, h, l);
    check(h == ph && l == ph, {tag, " R2 HCK phase"}, h * 100000 + l, ph * 100000 + ph);
    measure(ch, 1'b1, h, l);
    check(h == ps && l == ps, {tag, " R3 SCK phase"}, h * 100000 + l, ps * 100000 + ps);
  endtask

  task automatic t_odd();
    t_divided(0, 1'b0, 4, 2, "R4 odd 5x3");
    t_divided(1, 1'b0, 2, 0, "R4 odd 3x1");
  endtask

  task automatic t_bypass(input int ch, input int f);
    int bad, h, l;
    set_cfg(ch, 1'b1, 7, f, 1'b1, 1'b1);
    settle(ch);
    bad = 0;
    repeat (8) begin
      @(posedge clk); #1;
      if (hck_o[ch] !== 1'b1) bad++;
      @(negedge clk); #1;
      if (hck_o[ch] !== 1'b0) bad++;
    end
    check(bad == 0, "R5 bypass HCK follows source", bad, 0);
    measure(ch, 1'b1, h, l);
    check(h == f + 1 && l == f + 1, "R5 bypass SCK phase", h * 100000 + l,
          (f + 1) * 100000 + f + 1);
  endtask

  task automatic t_pin(input int ch, input int f);
    int h, l, bad, e;
    set_cfg(ch, 1'b0, 0, f, 1'b0, 1'b0);
    settle(ch);
    bad = 0;
    repeat (20) begin
      @(negedge clk);
      if (hck_o[ch] !== 1'b0) bad++;
    end
    check(bad == 0 && hck_oe_o[ch] == 1'b0, "R6 pin mode HCK quiet, enable low",
          bad * 10 + int'(hck_oe_o[ch]), 0);
    e = (f + 1) * EXT_HALF;
    measure(ch, 1'b1, h, l);
    check(h == e && l == e, "R6 pin mode SCK phase", h * 100000 + l, e * 100000 + e);
    set_cfg(ch, 1'b0, 1, 0, 1'b0, 1'b1);
    @(negedge clk);
    check(hck_oe_o[ch] == 1'b1, "R6 enable high when driving", int'(hck_oe_o[ch]), 1);
    settle(ch);
  endtask

  task automatic t_reprog();
    int h, l, n;
    for (int off = 0; off < 7; off++) begin
      mon_en = 1'b0;
      set_cfg(0, 1'b0, 2, 1, 1'b0, 1'b1);
      settle(0);
      measure(0, 1'b1, h, l);
      mon_en = 1'b1;
      n = 0;
      while (!sck_o[0] && n < LIMIT) begin
        @(negedge clk);
        n++;
      end
      repeat (off) @(negedge clk);
      set_cfg(0, 1'b0, 4, 0, 1'b0, 1'b1);
      for (int k = 0; k < 3; k++) begin
        measure(0, 1'b1, h, l);
        check((h == 5 || h == 6) && (l == 5 || l == 6), "R7 SCK phase old or new",
              h * 100000 + l, 5);
      end
      measure(0, 1'b1, h, l);
      check(h == 5 && l == 5, "R7 new setting in force", h * 100000 + l, 500005);
      mon_en = 1'b0;
      @(negedge clk);
      check(mon_bad == 0, "R7 HCK phase old or new", mon_bad, 0);
    end
  endtask

  task automatic t_indep();
    int h, l;
    set_cfg(0, 1'b0, 2, 1, 1'b0, 1'b1);
    set_cfg(1, 1'b1, 0, 2, 1'b0, 1'b1);
    settle(0);
    settle(1);
    measure(0, 1'b1, h, l);
    check(h == 6 && l == 6, "R8 transmit SCK", h * 100000 + l, 600006);
    measure(1, 1'b1, h, l);
    check(h == 24 && l == 24, "R8 receive SCK", h * 100000 + l, 2400024);
    set_cfg(1, 1'b0, 0, 0, 1'b1, 1'b1);
    settle(1);
    measure(0, 1'b0, h, l);
    check(h == 3 && l == 3, "R8 transmit HCK unaffected", h * 100000 + l, 300003);
    measure(0, 1'b1, h, l);
    check(h == 6 && l == 6, "R8 transmit SCK unaffected", h * 100000 + l, 600006);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < NCH; c++) ext_en[c] = 1'b0;
    t_reset();
    t_divided(0, 1'b0, 3, 1, "basic");
    t_divided(1, 1'b1, 2, 0, "prescale8");
    t_divided(0, 1'b0, 0, 0, "minimum");
    t_divided(1, 1'b0, 255, 0, "main max");
    t_divided(0, 1'b0, 1, 15, "fine max");
    t_odd();
    t_bypass(0, 4);
    t_bypass(1, 0);
    t_pin(1, 2);
    t_reprog();
    t_indep();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule